// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block runs an external byte-wide data memory over a narrow bus. The low address byte and the data byte share one 8-bit bus. An external latch captures the low byte on an address-latch strobe. The high address byte leaves on a separate port. An internal requester hands the block one read or write at a time through a valid/ready handshake. The block then runs the access as a fixed sequence of clock periods. It returns read data with a one-cycle valid strobe and marks each finished write with a one-cycle done pulse.

The strobe phase can be stretched by 0 to 3 wait cycles. A two-bit setting picks the number of wait cycles, and there are two such settings: one for the lower address page and one for the upper page. The page is chosen by comparing the request address with a programmable boundary. When an access ends, the final period becomes the address-latch period of the next access if a request is waiting. Otherwise the final period is a quiet cycle in which every bus output keeps its previous value.

The shared bus is exposed as separate output, output-enable and input vectors. The pad ring builds the tri-state buffer from them.

Top module: `xmem_mux_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, ale is 0, rd_n and wr_n are 1, ad_oe is 0, addr_hi is 0, rd_valid and wr_done are 0, and req_ready is 1.
- R2: The cycle after a request is accepted (req_valid and req_ready both high at a clock edge) is period T1. In T1, ale is 1, ad_oe is 1, ad_out is address bits 7..0 and addr_hi is address bits 15..8. ale lasts exactly one cycle.
- R3: The strobe starts in period T3 and stays low for exactly W+1 cycles, where W is the selected two-bit wait setting (0..3). A read drives only rd_n low and a write drives only wr_n low. Neither strobe is ever low while ale is 1. The access's own periods therefore end at T(3+W), and its final period is T(4+W).
- R4: An access whose address is greater than or equal to page_bound uses ws_upper. Any other access uses ws_lower. The setting is taken at the moment of acceptance.
- R5: In a write, from T2 through the last strobe cycle, ad_oe is 1 and ad_out equals the write data. wr_done is 1 for exactly one cycle, in the final period T(4+W).
- R6: In a read, ad_oe is 0 from T2 through the last strobe cycle. rd_data takes the value of ad_in at the clock edge that ends the last strobe cycle. rd_valid is 1 for exactly one cycle, in the final period T(4+W).
- R7: req_ready is 1 during the last strobe cycle. A request accepted there makes the final period the next access's T1, so the next access's ale pulse falls in that period.
- R8: If no request is accepted at the end of the last strobe cycle, ale stays 0 in the final period and in every later idle cycle. ad_out, ad_oe and addr_hi keep the values they had in the last strobe cycle until the next T1.
- R9: req_ready is 0 from T1 up to the cycle before the last strobe cycle. A request presented then is ignored: no ale pulse follows and addr_hi does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| page_bound | input | 16 | Lowest address of the upper page |
| ws_lower | input | 2 | Wait setting for the lower page |
| ws_upper | input | 2 | Wait setting for the upper page |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block can accept a request this cycle |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a new value |
| wr_done | output | 1 | One-cycle pulse: write finished |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| addr_hi | output | 8 | Address bits 15..8 |

## Verification
Every result is due a fixed number of cycles after the accepting edge. ale appears in the next cycle (T1). The bus turnaround happens in T2. The strobe covers cycles 3 through 3+W. rd_valid and wr_done fall in cycle 4+W, where W is computed in the bench from the address and the boundary. The bench drives inputs on the falling edge and samples at the next falling edge, one check per period. It keeps a pending-completion flag so that the done or valid pulse of a chained access is checked inside the next access's T1. The bench sweeps all sixteen pairs of lower and upper settings, with addresses on both sides of the boundary and exactly at it, and with chained and isolated accesses.

// File: rtl/xmem_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the multiplexed external memory controller.
// Assumes: nothing beyond IEEE 1800-2017.
package xmem_pkg;

    // Bus period the controller is currently in.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // quiet: outputs hold, waiting for a request
        PH_ALE   = 2'd1,  // T1: address latch strobe
        PH_SETUP = 2'd2,  // T2: bus turnaround / write data setup
        PH_STRB  = 2'd3   // T3..T3+W: read or write strobe active
    } xmem_phase_e;

endpackage

// File: rtl/xmem_page_sel.sv
`timescale 1ns/1ps
// Module: xmem_page_sel
// Picks the wait-state setting for a request by comparing its address with
// the page boundary. Purely combinational.
// Assumes: the boundary and both settings are stable while a request is offered.
module xmem_page_sel #(
    parameter int AW  = 16,
    parameter int WSW = 2
) (
    input  logic [AW-1:0]  addr,
    input  logic [AW-1:0]  bound,
    input  logic [WSW-1:0] ws_lo,
    input  logic [WSW-1:0] ws_hi,
    output logic [WSW-1:0] ws_sel
);

    logic in_upper;

    // Upper page: address at or above the boundary.
    always_comb begin
        in_upper = (addr >= bound);
        ws_sel   = in_upper ? ws_hi : ws_lo;
    end

endmodule

// File: rtl/xmem_seq.sv
`timescale 1ns/1ps
// Module: xmem_seq
// Period sequencer: walks ALE, SETUP and a stretched STROBE phase. It accepts
// a request when idle or in the last strobe cycle, so the final period of one
// access doubles as T1 of the next.
// Assumes: ws_in is valid whenever req_valid is high.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [WSW-1:0] ws_in,
    output xmem_phase_e    phase,
    output logic           req_ready,
    output logic           accept,
    output logic           last_strb
);

    localparam logic [WSW-1:0] CNT_ZERO = '0;

    xmem_phase_e    phase_q;
    logic [WSW-1:0] cnt_q;

    // Handshake and end-of-strobe decode.
    always_comb begin
        last_strb = (phase_q == PH_STRB) && (cnt_q == CNT_ZERO);
        req_ready = (phase_q == PH_IDLE) || last_strb;
        accept    = req_valid && req_ready;
        phase     = phase_q;
    end

    // Period register and remaining-wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= CNT_ZERO;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_ALE;
                        cnt_q   <= ws_in;
                    end
                end
                PH_ALE:   phase_q <= PH_SETUP;
                PH_SETUP: phase_q <= PH_STRB;
                PH_STRB: begin
                    if (cnt_q != CNT_ZERO) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (accept) begin
                        phase_q <= PH_ALE;
                        cnt_q   <= ws_in;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xmem_bus_drv.sv
`timescale 1ns/1ps
// Module: xmem_bus_drv
// Holds the accepted request, decodes the bus pins from the current period,
// captures read data and produces the completion pulses.
// Assumes: phase and last_strb come from xmem_seq in the same clock domain.
module xmem_bus_drv
    import xmem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  xmem_phase_e      phase,
    input  logic             last_strb,
    input  logic [DW-1:0]    ad_in,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             wr_done
);

    localparam int HW = AW - DW;

    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    // Request holding registers, read capture and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            wr_done  <= 1'b0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (last_strb && !wr_q) begin
                rd_data <= ad_in;
            end
            rd_valid <= last_strb && !wr_q;
            wr_done  <= last_strb && wr_q;
        end
    end

    // Pin decode from the period; idle keeps the last access's bus values.
    always_comb begin
        ale     = (phase == PH_ALE);
        rd_n    = !((phase == PH_STRB) && !wr_q);
        wr_n    = !((phase == PH_STRB) && wr_q);
        ad_oe   = ale || wr_q;
        ad_out  = (!ale && wr_q) ? wdata_q : addr_q[DW-1:0];
        addr_hi = addr_q[AW-1:AW-HW];
    end

endmodule

// File: rtl/xmem_mux_ctrl.sv
`timescale 1ns/1ps
// Module: xmem_mux_ctrl (top)
// External memory controller for a multiplexed low-address/data bus. It has
// per-page wait settings and chains back-to-back accesses.
// Assumes: the pad ring builds the tri-state bus from ad_out/ad_oe/ad_in, and
// an external latch captures ad_out while ale is high.
module xmem_mux_ctrl
    import xmem_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int WSW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    page_bound,
    input  logic [WSW-1:0]   ws_lower,
    input  logic [WSW-1:0]   ws_upper,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             wr_done,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic [AW-DW-1:0] addr_hi
);

    logic [WSW-1:0] ws_sel;
    xmem_phase_e    phase;
    logic           accept;
    logic           last_strb;

    xmem_page_sel #(.AW(AW), .WSW(WSW)) u_page (
        .addr   (req_addr),
        .bound  (page_bound),
        .ws_lo  (ws_lower),
        .ws_hi  (ws_upper),
        .ws_sel (ws_sel)
    );

    xmem_seq #(.WSW(WSW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ws_in     (ws_sel),
        .phase     (phase),
        .req_ready (req_ready),
        .accept    (accept),
        .last_strb (last_strb)
    );

    xmem_bus_drv #(.AW(AW), .DW(DW)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .last_strb (last_strb),
        .ad_in     (ad_in),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .addr_hi   (addr_hi),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .wr_done   (wr_done)
    );

endmodule

// File: rtl/xmem_mux_ctrl_chk.sv
`timescale 1ns/1ps
// Module: xmem_mux_ctrl_chk
// Protocol checker, bound to every xmem_mux_ctrl instance.
// Assumes: the same clock and synchronous active-low reset as the design.
module xmem_mux_ctrl_chk #(
    parameter int HW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          ale,
    input logic          rd_n,
    input logic          wr_n,
    input logic          ad_oe,
    input logic          rd_valid,
    input logic          wr_done,
    input logic [HW-1:0] addr_hi
);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)));

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R7
    ale_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> $past(req_valid && req_ready));

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R5
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    // R6
    rvalid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(rd_n));

    // R5
    wdone_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $rose(wr_n));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(addr_hi) && !ale));

endmodule

bind xmem_mux_ctrl xmem_mux_ctrl_chk #(.HW(AW-DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done),
    .addr_hi   (addr_hi)
);

// File: tb/xmem_mux_ctrl_bench.sv
`timescale 1ns/1ps
module xmem_mux_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] page_bound = 16'h8000;
    logic [1:0]  ws_lower = 2'd0;
    logic [1:0]  ws_upper = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  ad_in = 8'h0;
    logic        req_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        wr_done;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;

    int n_cmp = 0;
    int n_err = 0;
    bit finished = 1'b0;

    bit         pend_rd = 1'b0;
    bit         pend_wr = 1'b0;
    logic [7:0] pend_data = 8'h0;

    always #2 clk = ~clk;

    xmem_mux_ctrl u_xmem_mux_ctrl (
        .clk(clk), .rst_n(rst_n), .page_bound(page_bound),
        .ws_lower(ws_lower), .ws_upper(ws_upper),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .wr_done(wr_done), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .addr_hi(addr_hi)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_pending();
        chk(rd_valid == pend_rd, "R6 rd_valid in final period", rd_valid, pend_rd);
        chk(wr_done == pend_wr, "R5 wr_done in final period", wr_done, pend_wr);
        if (pend_rd)
            chk(rd_data == pend_data, "R6 rd_data capture", rd_data, pend_data);
        pend_rd = 1'b0;
        pend_wr = 1'b0;
    endtask

    // One access; called at a falling edge where req_ready is expected high.
    task automatic run(input bit wr, input logic [15:0] addr,
                       input logic [7:0] wd, input logic [7:0] din, input bit chain);
        int ws;
        // R4: page choice computed from the boundary
        ws = (addr >= page_bound) ? int'(ws_upper) : int'(ws_lower);
        chk(req_ready == 1'b1, "R7 ready before accept", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk); // T1
        chk(ale == 1'b1, "R2 ale in T1", ale, 1);
        chk(ad_oe == 1'b1 && ad_out == addr[7:0], "R2 low address in T1", ad_out, addr[7:0]);
        chk(addr_hi == addr[15:8], "R2 high address in T1", addr_hi, addr[15:8]);
        chk(req_ready == 1'b0, "R9 busy in T1", req_ready, 0);
        chk_pending();
        // R9: a request offered while busy must be ignored
        req_valid = 1'b1; req_write = !wr; req_addr = ~addr; req_wdata = ~wd;
        @(negedge clk); // T2
        chk(ale == 1'b0 && rd_n && wr_n, "R3 no strobe in T2", {ale, rd_n, wr_n}, 3'b011);
        chk(ad_oe == wr, "R5/R6 bus direction in T2", ad_oe, wr);
        if (wr) chk(ad_out == wd, "R5 write data in T2", ad_out, wd);
        chk(addr_hi == addr[15:8], "R9 addr_hi held while busy", addr_hi, addr[15:8]);
        ad_in = din;
        for (int i = 0; i <= ws; i++) begin
            @(negedge clk); // strobe cycle T3+i
            chk(rd_n == wr && wr_n == !wr, "R3 strobe active", {rd_n, wr_n}, {wr, !wr});
            chk(ale == 1'b0, "R9 no ale while busy", ale, 0);
            chk(ad_oe == wr, "R5/R6 bus direction in strobe", ad_oe, wr);
            if (wr) chk(ad_out == wd, "R5 write data in strobe", ad_out, wd);
            chk(req_ready == (i == ws), "R7/R9 ready only in last strobe", req_ready, i == ws);
        end
        if (wr) pend_wr = 1'b1;
        else begin pend_rd = 1'b1; pend_data = din; end
        if (!chain) begin
            req_valid = 1'b0;
            @(negedge clk); // final period T4+W, no next request
            chk(ale == 1'b0, "R8 no ale in quiet final period", ale, 0);
            chk(rd_n && wr_n, "R3 strobe ends at T3+W", {rd_n, wr_n}, 2'b11);
            chk_pending();
            chk(ad_oe == wr, "R8 ad_oe held", ad_oe, wr);
            chk(ad_out == (wr ? wd : addr[7:0]), "R8 ad_out held", ad_out, wr ? wd : addr[7:0]);
            chk(addr_hi == addr[15:8], "R8 addr_hi held", addr_hi, addr[15:8]);
            ad_in = ~din;
            @(negedge clk); // idle after the final period
            chk(!rd_valid && !wr_done, "R5/R6 single-cycle pulse", {rd_valid, wr_done}, 0);
            chk(ale == 1'b0 && ad_oe == wr && addr_hi == addr[15:8], "R8 idle hold",
                {ale, ad_oe, addr_hi}, {1'b0, wr, addr[15:8]});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held in reset
        chk(!ale && rd_n && wr_n && !ad_oe, "R1 pins in reset", {ale, rd_n, wr_n, ad_oe}, 4'b0110);
        chk(!rd_valid && !wr_done && addr_hi == 8'h0, "R1 status in reset",
            {rd_valid, wr_done, addr_hi}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !ale, "R1 ready after reset", {req_ready, ale}, 2'b10);
        for (int lo = 0; lo < 4; lo++) begin
            for (int hi = 0; hi < 4; hi++) begin
                logic [15:0] b;
                logic [7:0]  k;
                k = 8'(lo * 4 + hi);
                b = 16'h4000 + {k, 4'h3, 4'h0};
                ws_lower = 2'(lo); ws_upper = 2'(hi); page_bound = b;
                run(1'b1, b - 16'd1, 8'hA0 ^ k, 8'h00, 1'b0);
                run(1'b0, b, 8'h00, 8'h3C ^ k, 1'b1);
                run(1'b1, b + 16'h0105, 8'h5A + k, 8'h00, 1'b1);
                run(1'b0, b - 16'd1, 8'h00, 8'hC3 + k, 1'b0);
                run(1'b0, b + 16'h1000, 8'h00, 8'h96 ^ k, 1'b1);
                run(1'b0, 16'h0000, 8'h00, 8'h69 ^ k, 1'b0);
            end
        end
        // R4: extreme boundaries
        ws_lower = 2'd3; ws_upper = 2'd1; page_bound = 16'hFFFF;
        run(1'b1, 16'hFFFE, 8'h11, 8'h00, 1'b1);
        run(1'b0, 16'hFFFF, 8'h00, 8'h22, 1'b0);
        page_bound = 16'h0000;
        run(1'b0, 16'h0000, 8'h00, 8'h33, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule